// File: doc/BRIEF.md
# Integer Shift Unit with Status Flags

This block shifts an integer operand left, logically right or arithmetically right, at one of four operand sizes (8, 16, 32 or 64 bits), and produces the six arithmetic status flags that a general-purpose processor keeps beside its integer results. The shift amount is trimmed to five bits, or to six bits when the wide 64-bit mode indication is asserted. Only then is it compared with the operand size, so a trimmed amount may still exceed an 8-bit or 16-bit operand. A trimmed amount of zero is a no-op for the flags: every incoming flag is passed through unchanged.

The shift itself is combinational. The result and the flags are captured in output registers, so each answer appears one clock after its inputs. A new operation can be presented on every cycle. Two opcode values select the left shift; they are two spellings of one operation and give identical results.

Top module: `shf_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `result_o` and `flags_o` become zero. Otherwise, each output reflects the inputs sampled at the previous rising edge.
- R2: The effective count is `count_i` ANDed with 0x1F when `wide_i` is 0, and with 0x3F when `wide_i` is 1. Bits of `count_i` above the mask have no effect on any output.
- R3: When the effective count is zero, `result_o` equals `operand_i` with the bits above the selected size cleared, and `flags_o` equals `flags_i`.
- R4: Opcodes 2'b00 and 2'b01 both select the left shift and give identical outputs for identical inputs. The result is the sized operand shifted left by the count and truncated to the size. CF is the last bit shifted out of the top.
- R5: Opcode 2'b10 is the logical right shift, which fills with zeros. CF is the last bit shifted out of the bottom.
- R6: Opcode 2'b11 is the arithmetic right shift, which fills with copies of the sized operand's sign bit (bit size-1). CF is the last bit shifted out of the bottom.
- R7: Size is encoded as 2'b00 = 8, 2'b01 = 16, 2'b10 = 32 and 2'b11 = 64 bits. When the effective count is at least the size, the left and logical right shifts give a zero result with CF = 0. The arithmetic right shift gives a result that is entirely sign bits, with CF equal to the sign bit.
- R8: For an effective count of 1, OF depends on the opcode. For the left shift, OF is the result's top bit XOR the new CF. For the logical right shift, OF is the operand's original top bit. For the arithmetic right shift, OF is 0.
- R9: For any nonzero effective count, AF is 0. For an effective count greater than 1, OF is also 0.
- R10: For any nonzero effective count, SF is the result's top bit at the selected size, and ZF is 1 exactly when the result is zero. PF is 1 when bits 7:0 of the result contain an even number of ones.
- R11: The flag vector layout is bit 0 = CF, bit 1 = PF, bit 2 = AF, bit 3 = ZF, bit 4 = SF and bit 5 = OF. `result_o` bits above the selected size are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_i | input | 2 | Shift kind: 00/01 left, 10 logical right, 11 arithmetic right |
| size_i | input | 2 | Operand size: 00 = 8, 01 = 16, 10 = 32, 11 = 64 bits |
| wide_i | input | 1 | 64-bit mode with the wide-operand prefix; widens the count mask to six bits |
| count_i | input | CNT_W (8) | Raw shift amount before masking |
| operand_i | input | DATA_W (64) | Value to shift; bits above the size are ignored |
| flags_i | input | 6 | Incoming flags {OF,SF,ZF,AF,PF,CF} |
| result_o | output | DATA_W (64) | Registered shifted value, zero above the size |
| flags_o | output | 6 | Registered updated flags, same layout as `flags_i` |

## Verification
The bench builds the unit with its defaults: DATA_W = 64, which gives all four operand sizes, and CNT_W = 8, which leaves raw count bits 5 to 7 above the mask. With those three extra bits, the bench can offer counts such as 0x20, 0x40 and 0xE3 and check that they reduce to zero or to small amounts depending on the wide-mode input. The six-bit mask in wide mode lets the bench reach counts between 32 and 63 on 8-, 16- and 32-bit operands, where the count-at-least-size rules for the fill and for CF apply.

// File: rtl/shf_pkg.sv
// Package shf_pkg
// Shared encodings for the shift unit: opcodes, operand sizes and the
// bit positions of the flag vector.
package shf_pkg;

    typedef enum logic [1:0] {
        OP_LSH  = 2'b00,
        OP_LSH2 = 2'b01,
        OP_RSHL = 2'b10,
        OP_RSHA = 2'b11
    } shf_op_e;

    typedef enum logic [1:0] {
        SZ_8  = 2'b00,
        SZ_16 = 2'b01,
        SZ_32 = 2'b10,
        SZ_64 = 2'b11
    } shf_size_e;

    localparam int FLAG_W = 6;
    localparam int FL_CF  = 0;
    localparam int FL_PF  = 1;
    localparam int FL_AF  = 2;
    localparam int FL_ZF  = 3;
    localparam int FL_SF  = 4;
    localparam int FL_OF  = 5;

endpackage

// File: rtl/shf_count_mask.sv
// Module shf_count_mask
// Reduces the raw count to the effective shift amount: five bits in
// normal mode, six bits in wide mode. Also flags an effective count of
// zero. Assumes that CNT_W is greater than SH_W.
module shf_count_mask #(
    parameter int CNT_W = 8,
    parameter int SH_W  = 6
) (
    input  logic [CNT_W-1:0] count_i,
    input  logic             wide_i,
    output logic [SH_W-1:0]  cnt_o,
    output logic             zero_o
);

    logic unused_high_cnt;

    // Discard the raw count bits that no mode can use.
    assign unused_high_cnt = ^count_i[CNT_W-1:SH_W];

    // Keep the top count bit only in wide mode.
    always_comb begin
        cnt_o  = {wide_i & count_i[SH_W-1], count_i[SH_W-2:0]};
        zero_o = (cnt_o == '0);
    end

endmodule

// File: rtl/shf_datapath.sv
// Module shf_datapath
// Combinational shifter for all three shift kinds at four operand sizes.
// It returns the sized result, the last bit shifted out and the
// operand's original top bit. Assumes that DATA_W is 64 and that
// SH_W is $clog2(DATA_W).
module shf_datapath
    import shf_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int SH_W   = 6
) (
    input  logic [1:0]        op_i,
    input  logic [1:0]        size_i,
    input  logic [SH_W-1:0]   cnt_i,
    input  logic [DATA_W-1:0] operand_i,
    output logic [DATA_W-1:0] result_o,
    output logic              cf_o,
    output logic              msb_in_o
);

    localparam int NUM_SZ = SH_W - 2;

    logic [DATA_W-1:0]        lane_mask [NUM_SZ];
    logic [NUM_SZ-1:0]        lane_msb;
    logic [DATA_W-1:0]        wmask;
    logic [SH_W:0]            wbits;
    logic [DATA_W-1:0]        aw;
    logic [DATA_W-1:0]        sx;
    logic [DATA_W:0]          ext_l;
    logic [DATA_W:0]          ext_r;
    logic signed [DATA_W:0]   sar_in;
    logic signed [DATA_W:0]   ext_a;
    logic                     beyond;

    // Build one lane mask and one sign tap for each operand size.
    generate
        for (genvar k = 0; k < NUM_SZ; k++) begin : g_lane
            assign lane_mask[k] = {DATA_W{1'b1}} >> (DATA_W - (8 << k));
            assign lane_msb[k]  = operand_i[(8 << k) - 1];
        end
    endgenerate

    // Select the size, trim the operand and sign-extend it.
    always_comb begin
        wmask    = lane_mask[size_i];
        wbits    = (SH_W+1)'(8 << size_i);
        msb_in_o = lane_msb[size_i];
        aw       = operand_i & wmask;
        sx       = aw | (msb_in_o ? ~wmask : '0);
        sar_in   = {sx, 1'b0};
        beyond   = ({1'b0, cnt_i} >= wbits);
    end

    // Run the three shifters; each carries one spare bit for CF.
    always_comb begin
        ext_l = {1'b0, aw} << cnt_i;
        ext_r = {aw, 1'b0} >> cnt_i;
        ext_a = sar_in >>> cnt_i;
    end

    // Pick the requested kind and apply the count-at-least-size rule.
    always_comb begin
        if (op_i == OP_RSHA) begin
            result_o = ext_a[DATA_W:1] & wmask;
            cf_o     = ext_a[0];
        end else if (op_i == OP_RSHL) begin
            result_o = beyond ? '0 : ext_r[DATA_W:1];
            cf_o     = beyond ? 1'b0 : ext_r[0];
        end else begin
            result_o = beyond ? '0 : (ext_l[DATA_W-1:0] & wmask);
            cf_o     = beyond ? 1'b0 : ext_l[wbits];
        end
    end

endmodule

// File: rtl/shf_flag_gen.sv
// Module shf_flag_gen
// Produces the outgoing flag vector. A zero count passes the incoming
// flags through unchanged. Any other count recomputes all six flags
// from the result, clearing the flags that the shift leaves undefined.
module shf_flag_gen
    import shf_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int SH_W   = 6
) (
    input  logic [1:0]        op_i,
    input  logic [1:0]        size_i,
    input  logic [SH_W-1:0]   cnt_i,
    input  logic              zero_i,
    input  logic [DATA_W-1:0] result_i,
    input  logic              cf_i,
    input  logic              msb_in_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic [FLAG_W-1:0] flags_o
);

    localparam int NUM_SZ = SH_W - 2;

    logic [NUM_SZ-1:0] res_msb;
    logic              top;
    logic              one_bit;
    logic              of_new;

    // Tap the result's top bit for each operand size.
    generate
        for (genvar k = 0; k < NUM_SZ; k++) begin : g_msb
            assign res_msb[k] = result_i[(8 << k) - 1];
        end
    endgenerate

    // Work out OF for a single-bit shift of each kind.
    always_comb begin
        top     = res_msb[size_i];
        one_bit = (cnt_i == SH_W'(1));
        case (op_i)
            OP_RSHA: of_new = 1'b0;
            OP_RSHL: of_new = msb_in_i;
            default: of_new = top ^ cf_i;
        endcase
    end

    // Assemble the outgoing flags, or pass the incoming ones through.
    always_comb begin
        if (zero_i) begin
            flags_o = flags_i;
        end else begin
            flags_o        = '0;
            flags_o[FL_CF] = cf_i;
            flags_o[FL_PF] = ~^result_i[7:0];
            flags_o[FL_AF] = 1'b0;
            flags_o[FL_ZF] = (result_i == '0);
            flags_o[FL_SF] = top;
            flags_o[FL_OF] = one_bit & of_new;
        end
    end

endmodule

// File: rtl/shf_unit.sv
// Module shf_unit (top)
// Integer shift unit with registered result and flags. The count is
// masked before any comparison with the size. The outputs appear one
// cycle after the inputs. Reset is synchronous and active low.
module shf_unit
    import shf_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        op_i,
    input  logic [1:0]        size_i,
    input  logic              wide_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic [5:0]        flags_i,
    output logic [DATA_W-1:0] result_o,
    output logic [5:0]        flags_o
);

    localparam int SH_W = $clog2(DATA_W);

    logic [SH_W-1:0]   cnt;
    logic              cnt_zero;
    logic [DATA_W-1:0] res_c;
    logic              cf_c;
    logic              msb_in;
    logic [FLAG_W-1:0] flags_c;

    shf_count_mask #(.CNT_W(CNT_W), .SH_W(SH_W)) u_mask (
        .count_i (count_i),
        .wide_i  (wide_i),
        .cnt_o   (cnt),
        .zero_o  (cnt_zero)
    );

    shf_datapath #(.DATA_W(DATA_W), .SH_W(SH_W)) u_path (
        .op_i      (op_i),
        .size_i    (size_i),
        .cnt_i     (cnt),
        .operand_i (operand_i),
        .result_o  (res_c),
        .cf_o      (cf_c),
        .msb_in_o  (msb_in)
    );

    shf_flag_gen #(.DATA_W(DATA_W), .SH_W(SH_W)) u_flags (
        .op_i     (op_i),
        .size_i   (size_i),
        .cnt_i    (cnt),
        .zero_i   (cnt_zero),
        .result_i (res_c),
        .cf_i     (cf_c),
        .msb_in_i (msb_in),
        .flags_i  (flags_i),
        .flags_o  (flags_c)
    );

    // Capture the result and flags, clearing both during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            flags_o  <= '0;
        end else begin
            result_o <= res_c;
            flags_o  <= flags_c;
        end
    end

endmodule

// File: rtl/shf_unit_chk.sv
// Module shf_unit_chk
// Checker bound to shf_unit. It relates the registered outputs to the
// inputs of the previous cycle.
module shf_unit_chk #(
    parameter int DATA_W = 64,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        op_i,
    input logic [1:0]        size_i,
    input logic              wide_i,
    input logic [CNT_W-1:0]  count_i,
    input logic [DATA_W-1:0] operand_i,
    input logic [5:0]        flags_i,
    input logic [DATA_W-1:0] result_o,
    input logic [5:0]        flags_o
);

    logic [5:0]        eff;
    logic [6:0]        wb;
    logic [DATA_W-1:0] sized_in;
    logic              unused_chk_bits;

    // Recompute the effective count, the size in bits and the sized operand.
    always_comb begin
        eff             = {wide_i & count_i[5], count_i[4:0]};
        wb              = 7'(8 << size_i);
        sized_in        = operand_i & ({DATA_W{1'b1}} >> (DATA_W - int'(wb)));
        unused_chk_bits = ^count_i[CNT_W-1:6];
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (result_o == '0 && flags_o == '0));

    // R3
    zero_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eff == 6'd0) |=> (flags_o == $past(flags_i)));

    // R3
    zero_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eff == 6'd0) |=> (result_o == $past(sized_in)));

    // R7
    clear_beyond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != 2'b11 && {1'b0, eff} >= wb) |=> (result_o == '0 && !flags_o[0]));

    // R8
    sar_of_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 2'b11 && eff == 6'd1) |=> !flags_o[5]);

    // R9
    af_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eff != 6'd0) |=> !flags_o[2]);

    // R9
    of_multi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eff > 6'd1) |=> !flags_o[5]);

    // R10
    zf_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eff != 6'd0) |=> (flags_o[3] == (result_o == '0)));

endmodule

bind shf_unit shf_unit_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_i      (op_i),
    .size_i    (size_i),
    .wide_i    (wide_i),
    .count_i   (count_i),
    .operand_i (operand_i),
    .flags_i   (flags_i),
    .result_o  (result_o),
    .flags_o   (flags_o)
);

// File: tb/tb_shf_unit.sv
// Directed bench for shf_unit. One task per scenario; every task checks
// its own results against a bit-serial model of the requirements.
module tb_shf_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  op_i = '0;
    logic [1:0]  size_i = '0;
    logic        wide_i = 1'b0;
    logic [7:0]  count_i = '0;
    logic [63:0] operand_i = '0;
    logic [5:0]  flags_i = '0;
    logic [63:0] result_o;
    logic [5:0]  flags_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    shf_unit dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .size_i(size_i),
        .wide_i(wide_i), .count_i(count_i), .operand_i(operand_i),
        .flags_i(flags_i), .result_o(result_o), .flags_o(flags_o)
    );

    // Model: shifts one bit at a time, then applies the documented overrides.
    function automatic logic [69:0] model(input logic [1:0] op, input logic [1:0] sz,
                                          input logic wd, input logic [7:0] craw,
                                          input logic [63:0] a, input logic [5:0] fin);
        int w;
        int n;
        logic [63:0] v;
        logic msb0;
        logic cf;
        logic of;
        logic [5:0] f;
        w = 8 << sz;
        n = wd ? int'(craw & 8'h3F) : int'(craw & 8'h1F);
        v = '0;
        for (int i = 0; i < w; i++) v[i] = a[i];
        if (n == 0) return {v, fin};
        msb0 = v[w-1];
        cf = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (op[1] == 1'b0) begin
                cf = v[w-1];
                v = v << 1;
                if (w < 64) v[w] = 1'b0;
            end else begin
                cf = v[0];
                v = v >> 1;
                if (op[0]) v[w-1] = msb0;
            end
        end
        if (op != 2'b11 && n >= w) begin
            v = '0;
            cf = 1'b0;
        end
        if (n != 1) of = 1'b0;
        else if (op[1] == 1'b0) of = v[w-1] ^ cf;
        else if (op == 2'b10) of = msb0;
        else of = 1'b0;
        f = {of, v[w-1], (v == 64'd0), 1'b0, ~^v[7:0], cf};
        return {v, f};
    endfunction

    task automatic compare(input string tag, input logic [63:0] er, input logic [5:0] ef);
        n_chk++;
        if (result_o !== er || flags_o !== ef) begin
            n_bad++;
            $display("FAIL %s: result=%h flags=%b expected result=%h flags=%b",
                     tag, result_o, flags_o, er, ef);
        end
    endtask

    // Drive at the falling edge, let one rising edge register, sample at the next fall.
    task automatic run(input string tag, input logic [1:0] op, input logic [1:0] sz,
                       input logic wd, input logic [7:0] c, input logic [63:0] a,
                       input logic [5:0] fin);
        logic [69:0] exp;
        @(negedge clk);
        op_i = op; size_i = sz; wide_i = wd; count_i = c; operand_i = a; flags_i = fin;
        exp = model(op, sz, wd, c, a, fin);
        @(negedge clk);
        compare(tag, exp[69:6], exp[5:0]);
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst_n = 1'b0;
        op_i = 2'b00; count_i = 8'd0; operand_i = 64'hFFFF; flags_i = 6'h3F;
        @(negedge clk);
        compare("R1 reset clears outputs", 64'd0, 6'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_mask;
        run("R2 narrow mask 0x21->1", 2'b00, 2'b10, 1'b0, 8'h21, 64'h8000_0001, 6'h00);
        run("R2 wide mask 0x21->33", 2'b10, 2'b11, 1'b1, 8'h21, 64'hF000_0000_0000_0000, 6'h00);
        run("R2 wide mask 0xE3->35", 2'b11, 2'b11, 1'b1, 8'hE3, 64'h8000_0000_0000_0000, 6'h00);
        run("R2 high bits ignored 0xC5", 2'b10, 2'b01, 1'b0, 8'hC5, 64'h0000_ABCD, 6'h00);
    endtask

    task automatic t_zero;
        run("R3 zero count 0x20 narrow", 2'b00, 2'b00, 1'b0, 8'h20, 64'hFFFF_FF5A, 6'h2B);
        run("R3 zero count 0x40 wide", 2'b11, 2'b11, 1'b1, 8'h40, 64'h8123_4567_89AB_CDEF, 6'h15);
        run("R3 zero count keeps flags", 2'b10, 2'b01, 1'b0, 8'h00, 64'h1234_8001, 6'h3F);
    endtask

    task automatic t_left;
        run("R4 shl 8-bit by 3", 2'b00, 2'b00, 1'b0, 8'd3, 64'h0000_00B5, 6'h00);
        run("R4 sal alias 8-bit by 3", 2'b01, 2'b00, 1'b0, 8'd3, 64'h0000_00B5, 6'h00);
        run("R4 shl 32-bit by 31", 2'b00, 2'b10, 1'b0, 8'd31, 64'h0000_0003, 6'h00);
        run("R4 sal alias 64-bit by 63", 2'b01, 2'b11, 1'b1, 8'd63, 64'h3, 6'h00);
    endtask

    task automatic t_right;
        run("R5 shr 16-bit by 4", 2'b10, 2'b01, 1'b0, 8'd4, 64'hFFFF_9ABC, 6'h00);
        run("R5 shr 64-bit by 40", 2'b10, 2'b11, 1'b1, 8'd40, 64'hDEAD_BEEF_0080_0000, 6'h00);
        run("R6 sar 8-bit negative by 2", 2'b11, 2'b00, 1'b0, 8'd2, 64'h0000_0086, 6'h00);
        run("R6 sar 32-bit positive by 5", 2'b11, 2'b10, 1'b0, 8'd5, 64'hFFFF_FFFF_7FFF_FFF0, 6'h00);
        run("R6 sar 64-bit negative by 60", 2'b11, 2'b11, 1'b1, 8'd60, 64'h9000_0000_0000_0000, 6'h00);
    endtask

    task automatic t_beyond;
        run("R7 shl 8-bit count 12", 2'b00, 2'b00, 1'b0, 8'd12, 64'h0000_00FF, 6'h00);
        run("R7 shl 8-bit count equal 8", 2'b00, 2'b00, 1'b0, 8'd8, 64'h0000_00FF, 6'h00);
        run("R7 shr 16-bit count 20", 2'b10, 2'b01, 1'b0, 8'd20, 64'h0000_FFFF, 6'h00);
        run("R7 sar 8-bit negative count 20", 2'b11, 2'b00, 1'b0, 8'd20, 64'h0000_0080, 6'h00);
        run("R7 sar 16-bit positive count 16", 2'b11, 2'b01, 1'b0, 8'd16, 64'h0000_7FFF, 6'h00);
        run("R7 shr 32-bit wide count 40", 2'b10, 2'b10, 1'b1, 8'd40, 64'hFFFF_FFFF, 6'h00);
    endtask

    task automatic t_of;
        run("R8 shl by 1 sign change", 2'b00, 2'b00, 1'b0, 8'd1, 64'h0000_0040, 6'h00);
        run("R8 shl by 1 no change", 2'b00, 2'b00, 1'b0, 8'd1, 64'h0000_00C0, 6'h00);
        run("R8 shr by 1 top set", 2'b10, 2'b01, 1'b0, 8'd1, 64'h0000_8001, 6'h00);
        run("R8 sar by 1 negative", 2'b11, 2'b10, 1'b0, 8'd1, 64'h8000_0001, 6'h20);
        run("R9 of and af cleared count 2", 2'b00, 2'b00, 1'b0, 8'd2, 64'h0000_0040, 6'h24);
    endtask

    task automatic t_flags;
        run("R10 zero result sets zf pf", 2'b10, 2'b00, 1'b0, 8'd4, 64'h0000_000F, 6'h00);
        run("R10 odd parity result", 2'b00, 2'b01, 1'b0, 8'd1, 64'h0000_0001, 6'h3F);
        run("R10 sign at 16-bit", 2'b00, 2'b01, 1'b0, 8'd15, 64'h0000_0001, 6'h00);
        run("R11 upper bits cleared 16-bit", 2'b11, 2'b01, 1'b0, 8'd3, 64'hFFFF_FFFF_FFFF_8000, 6'h00);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: expired expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_mask();
        t_zero();
        t_left();
        t_right();
        t_beyond();
        t_of();
        t_flags();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule